// File: doc/BRIEF.md
# Work-RAM Gate Controller

This block sits between two system buses and a 128 KB byte-wide work RAM. On the 24-bit A bus the RAM shows up in two places: two whole banks that cover the full array, and an 8 KB window at the bottom of every bank in the lower half of each 128-bank group, which always lands in the first 8 KB of the array. On the 8-bit B bus the RAM is reached through a single byte-wide data gate whose target is a 17-bit pointer. Software loads the pointer through three B-bus registers. A DMA engine can then stream bytes through the gate, and the pointer steps after each byte.

Both buses can ask for the array in the same cycle, but the array serves one access per cycle. The A bus has priority. A B-bus gate access that loses is not acknowledged. If its requester keeps asking, it is served in the next cycle ahead of the A bus, so neither side waits longer than one cycle. The array is external and synchronous: a read issued in one cycle returns its byte in the next, flagged by a per-bus read-valid.

Top module: `wram_gate`

## Requirements
- R1: An A-bus access to bank $7E or $7F is acknowledged and drives the RAM at offset {bank bit 0, address bits 15:0}.
- R2: An A-bus access to offsets $0000-$1FFF of any bank in $00-$3F or $80-$BF is acknowledged and drives the RAM at the same 13-bit offset with bits 16:13 zero, so it always reaches the first 8 KB of bank $7E.
- R3: Any other A-bus address (for example $00:2000, $00:2180, $40:0000, $7D:FFFF, $C0:0000) gets no acknowledge and causes no RAM access.
- R4: A B-bus access to address $80 is acknowledged when granted and drives the RAM at the pointer value. It is a write when b_we is 1 and a read otherwise.
- R5: B-bus writes to $81, $82 and $83 load pointer bits 7:0, bits 15:8 and bit 16 (from data bit 0). They are acknowledged at once and start no RAM access.
- R6: After every granted access at $80, whether a read or a write, the pointer increases by one and wraps from $1FFFF to $00000.
- R7: B-bus reads of $81-$83 are acknowledged, start no RAM access, raise no read-valid and leave the pointer unchanged.
- R8: When an A-bus RAM access and a B-bus $80 access arrive in the same cycle, A is granted and B is not acknowledged. If B is still requesting in the next cycle, B is granted and any A request in that cycle is not acknowledged.
- R9: A granted read raises a_rvalid or b_rvalid in the following cycle, with the addressed byte on a_rdata or b_rdata.
- R10: Reset clears the pointer to zero, clears both read-valids and clears any pending B wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | A-bus access request |
| a_we | input | 1 | A-bus write (1) or read (0) |
| a_addr | input | 24 | A-bus address, bank in bits 23:16 |
| a_wdata | input | 8 | A-bus write data |
| a_ack | output | 1 | A-bus access accepted this cycle |
| a_rvalid | output | 1 | A-bus read data valid |
| a_rdata | output | 8 | A-bus read data |
| b_req | input | 1 | B-bus access request |
| b_we | input | 1 | B-bus write (1) or read (0) |
| b_addr | input | 8 | B-bus register address |
| b_wdata | input | 8 | B-bus write data |
| b_ack | output | 1 | B-bus access accepted this cycle |
| b_rvalid | output | 1 | B-bus gate read data valid |
| b_rdata | output | 8 | B-bus read data |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 17 | RAM byte offset |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after a read |

## Verification
The bench targets the edges of the address map. It probes the last mirrored byte $1FFF next to the first unmapped one, and bank $7F next to the mirror. A decoder that let the mirror reach bank $7F, or that passed $2000 or $2180, would show a wrong ram_addr or a stray acknowledge. It loads the pointer just below $1FFFF and streams through the wrap, where a pointer that carried into a missing bit or stopped at the top would store bytes at the wrong offsets. It reads the pointer registers between gate accesses; a pointer that moved on such a read would put the next gate byte at a shifted address. It also drives A and B requests together for several cycles to catch an arbiter that starves B or serves both sides in one cycle.

// File: rtl/wram_gate_pkg.sv
package wram_gate_pkg;
    // array offset width and low-window width
    localparam int OFS_W    = 17;
    localparam int MIRROR_W = 13;
    // B-bus register block: four consecutive addresses starting at the gate
    localparam logic [7:0] B_GATE_ADDR = 8'h80;
    localparam logic [1:0] SEL_GATE    = 2'd0;
    localparam logic [1:0] SEL_LO      = 2'd1;
    localparam logic [1:0] SEL_MID     = 2'd2;
    localparam logic [1:0] SEL_HI      = 2'd3;

    typedef struct packed {
        logic b_wait;
        logic a_rv;
        logic b_rv;
    } arb_state_t;
endpackage

// File: rtl/wram_gate_adec.sv
module wram_gate_adec #(
    parameter int OFS_W    = wram_gate_pkg::OFS_W,
    parameter int MIRROR_W = wram_gate_pkg::MIRROR_W
) (
    input  logic             req,
    input  logic [23:0]      addr,
    output logic             hit,
    output logic             mirror,
    output logic [OFS_W-1:0] ofs
);
    logic [7:0] bank;
    logic       direct;

    always_comb begin
        bank   = addr[23:16];
        direct = (bank[7:1] == 7'h3F);
        mirror = !bank[6] && (addr[15:MIRROR_W] == '0);
        ofs    = '0;
        if (direct) begin
            ofs = OFS_W'({bank[0], addr[15:0]});
        end else if (mirror) begin
            ofs[MIRROR_W-1:0] = addr[MIRROR_W-1:0];
        end
        hit = req && (direct || mirror);
    end
endmodule

// File: rtl/wram_gate_ptr.sv
module wram_gate_ptr #(
    parameter int OFS_W = wram_gate_pkg::OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       sel,
    input  logic [7:0]       wdata,
    input  logic             step,
    output logic [OFS_W-1:0] ptr
);
    import wram_gate_pkg::*;
    localparam int HI_W = OFS_W - 16;

    typedef struct packed {
        logic [OFS_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end else if (wr_en) begin
            case (sel)
                SEL_LO:  st_d.ptr[7:0]         = wdata;
                SEL_MID: st_d.ptr[15:8]        = wdata;
                SEL_HI:  st_d.ptr[OFS_W-1:16]  = wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;

    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ptr == OFS_W'($past(ptr) + 1'b1));
    a_r5_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !step && sel == SEL_LO) |=>
            (ptr[7:0] == $past(wdata) && ptr[OFS_W-1:8] == $past(ptr[OFS_W-1:8])));
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !step) |=> $stable(ptr));
endmodule

// File: rtl/wram_gate_arb.sv
module wram_gate_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic a_hit,
    input  logic a_we,
    input  logic b_port,
    input  logic b_we,
    output logic a_grant,
    output logic b_grant,
    output logic a_rvalid,
    output logic b_rvalid
);
    import wram_gate_pkg::*;

    arb_state_t st_d, st_q;

    always_comb begin
        b_grant     = b_port && (!a_hit || st_q.b_wait);
        a_grant     = a_hit && !b_grant;
        st_d.b_wait = b_port && !b_grant;
        st_d.a_rv   = a_grant && !a_we;
        st_d.b_rv   = b_grant && !b_we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_rvalid = st_q.a_rv;
    assign b_rvalid = st_q.b_rv;

    a_r8_b_next: assert property (@(posedge clk) disable iff (!rst_n)
        (b_port && !b_grant) |=> (!b_port || b_grant));
    a_r9_a_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (a_grant && !a_we) |=> a_rvalid);
    a_r8_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && b_port) |-> (a_grant != b_grant));
endmodule

// File: rtl/wram_gate.sv
module wram_gate #(
    parameter int OFS_W    = wram_gate_pkg::OFS_W,
    parameter int MIRROR_W = wram_gate_pkg::MIRROR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_req,
    input  logic             a_we,
    input  logic [23:0]      a_addr,
    input  logic [7:0]       a_wdata,
    output logic             a_ack,
    output logic             a_rvalid,
    output logic [7:0]       a_rdata,
    input  logic             b_req,
    input  logic             b_we,
    input  logic [7:0]       b_addr,
    input  logic [7:0]       b_wdata,
    output logic             b_ack,
    output logic             b_rvalid,
    output logic [7:0]       b_rdata,
    output logic             ram_en,
    output logic             ram_we,
    output logic [OFS_W-1:0] ram_addr,
    output logic [7:0]       ram_wdata,
    input  logic [7:0]       ram_rdata
);
    import wram_gate_pkg::*;

    logic             a_hit, a_mirror;
    logic [OFS_W-1:0] a_ofs;
    logic             b_in_blk, b_port, preg_wr;
    logic             a_grant, b_grant;
    logic [OFS_W-1:0] ptr;

    wram_gate_adec #(.OFS_W(OFS_W), .MIRROR_W(MIRROR_W)) adec_i (
        .req(a_req), .addr(a_addr), .hit(a_hit), .mirror(a_mirror), .ofs(a_ofs)
    );

    always_comb begin
        b_in_blk = b_req && (b_addr[7:2] == B_GATE_ADDR[7:2]);
        b_port   = b_in_blk && (b_addr[1:0] == SEL_GATE);
        preg_wr  = b_in_blk && (b_addr[1:0] != SEL_GATE) && b_we;
    end

    wram_gate_arb arb_i (
        .clk(clk), .rst_n(rst_n),
        .a_hit(a_hit), .a_we(a_we), .b_port(b_port), .b_we(b_we),
        .a_grant(a_grant), .b_grant(b_grant),
        .a_rvalid(a_rvalid), .b_rvalid(b_rvalid)
    );

    wram_gate_ptr #(.OFS_W(OFS_W)) ptr_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(preg_wr), .sel(b_addr[1:0]), .wdata(b_wdata),
        .step(b_grant), .ptr(ptr)
    );

    always_comb begin
        a_ack     = a_grant;
        b_ack     = b_port ? b_grant : b_in_blk;
        ram_en    = a_grant || b_grant;
        ram_we    = a_grant ? a_we : (b_grant && b_we);
        ram_addr  = a_grant ? a_ofs : ptr;
        ram_wdata = a_grant ? a_wdata : b_wdata;
    end

    assign a_rdata = ram_rdata;
    assign b_rdata = ram_rdata;

    a_r2_mirror_low: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ack && a_mirror) |-> (ram_addr >> MIRROR_W) == '0);
    a_r3_ram_owner: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (a_ack || b_ack));
    a_r5_preg_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && b_addr[7:2] == B_GATE_ADDR[7:2] && b_addr[1:0] != SEL_GATE) |-> (ram_en == a_ack));
endmodule

// File: tb/wram_gate_tb_top.sv
module wram_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_req, a_we, b_req, b_we;
    logic [23:0] a_addr;
    logic [7:0]  a_wdata, b_addr, b_wdata;
    logic        a_ack, a_rvalid, b_ack, b_rvalid;
    logic [7:0]  a_rdata, b_rdata;
    logic        ram_en, ram_we;
    logic [16:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;

    always #2 clk = ~clk;

    wram_gate dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_ack(a_ack), .a_rvalid(a_rvalid), .a_rdata(a_rdata),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_ack(b_ack), .b_rvalid(b_rvalid), .b_rdata(b_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // behavioural storage array
    logic [7:0] arr [int];
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) arr[int'(ram_addr)] = ram_wdata;
            else ram_rdata <= arr.exists(int'(ram_addr)) ? arr[int'(ram_addr)] : 8'h00;
        end
    end

    // reference model state
    logic [7:0] m_mem [int];
    int         m_ptr;
    bit         m_wait, e_arv, e_brv;
    logic [7:0] e_rd;
    int         n_cmp = 0, n_bad = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_rd(input int a);
        return m_mem.exists(a) ? m_mem[a] : 8'h00;
    endfunction

    task automatic cyc(input string req,
                       input bit ar, input bit aw, input logic [23:0] aa, input logic [7:0] ad,
                       input bit br, input bit bw, input logic [7:0] ba, input logic [7:0] bd);
        bit hit, bport, bblk, bwin, agr;
        int bank, ofs;
        @(negedge clk);
        a_req = ar; a_we = aw; a_addr = aa; a_wdata = ad;
        b_req = br; b_we = bw; b_addr = ba; b_wdata = bd;
        #1;
        bank = int'(aa[23:16]);
        hit = 0; ofs = 0;
        if (ar) begin
            if (bank == 'h7E || bank == 'h7F) begin
                hit = 1; ofs = (bank - 'h7E) * 65536 + int'(aa[15:0]);
            end else if ((bank < 'h40 || (bank >= 'h80 && bank < 'hC0)) && aa[15:0] < 16'h2000) begin
                hit = 1; ofs = int'(aa[15:0]);
            end
        end
        bblk  = br && (ba >= 8'h80 && ba <= 8'h83);
        bport = bblk && ba == 8'h80;
        bwin  = bport && (!hit || m_wait);
        agr   = hit && !bwin;
        // previous-cycle read results
        chk(req, "a_rvalid", a_rvalid, e_arv);
        if (e_arv) chk(req, "a_rdata", a_rdata, e_rd);
        chk(req, "b_rvalid", b_rvalid, e_brv);
        if (e_brv) chk(req, "b_rdata", b_rdata, e_rd);
        chk(req, "a_ack", a_ack, agr);
        chk(req, "b_ack", b_ack, bport ? bwin : bblk);
        chk(req, "ram_en", ram_en, agr || bwin);
        if (agr || bwin) begin
            chk(req, "ram_addr", ram_addr, agr ? ofs : m_ptr);
            chk(req, "ram_we", ram_we, agr ? aw : bw);
            if (agr ? aw : bw) chk(req, "ram_wdata", ram_wdata, agr ? ad : bd);
        end
        // advance model
        e_arv = agr && !aw;
        e_brv = bwin && !bw;
        if (agr) begin
            if (aw) m_mem[ofs] = ad; else e_rd = m_rd(ofs);
        end
        if (bwin) begin
            if (bw) m_mem[m_ptr] = bd; else e_rd = m_rd(m_ptr);
            m_ptr = (m_ptr + 1) % 131072;
        end else if (bblk && bw) begin
            if (ba == 8'h81) m_ptr = (m_ptr & 'h1FF00) | int'(bd);
            if (ba == 8'h82) m_ptr = (m_ptr & 'h100FF) | (int'(bd) << 8);
            if (ba == 8'h83) m_ptr = (m_ptr & 'h0FFFF) | (int'(bd[0]) << 16);
        end
        m_wait = bport && !bwin;
    endtask

    task automatic idle(input string req);
        cyc(req, 0, 0, 24'h0, 8'h0, 0, 0, 8'h0, 8'h0);
    endtask

    task automatic set_ptr(input string req, input int p);
        cyc(req, 0, 0, 24'h0, 8'h0, 1, 1, 8'h81, p[7:0]);
        cyc(req, 0, 0, 24'h0, 8'h0, 1, 1, 8'h82, p[15:8]);
        cyc(req, 0, 0, 24'h0, 8'h0, 1, 1, 8'h83, {7'h0, p[16]});
    endtask

    task automatic run_all();
        // R10: reset state, then the first gate access lands at offset 0
        chk("R10", "a_rvalid", a_rvalid, 0);
        chk("R10", "b_rvalid", b_rvalid, 0);
        cyc("R10", 0, 0, 24'h0, 8'h0, 1, 1, 8'h80, 8'h3C);
        idle("R10");
        // R1: direct banks
        cyc("R1", 1, 1, 24'h7E1234, 8'hAA, 0, 0, 8'h0, 8'h0);
        cyc("R1", 1, 1, 24'h7F1234, 8'hBB, 0, 0, 8'h0, 8'h0);
        cyc("R1", 1, 0, 24'h7E1234, 8'h00, 0, 0, 8'h0, 8'h0);
        cyc("R9", 1, 0, 24'h7FFFFF, 8'h00, 0, 0, 8'h0, 8'h0);
        cyc("R1", 1, 0, 24'h7F1234, 8'h00, 0, 0, 8'h0, 8'h0);
        idle("R9");
        // R2: low mirror
        cyc("R2", 1, 1, 24'h000010, 8'h11, 0, 0, 8'h0, 8'h0);
        cyc("R2", 1, 1, 24'h801FFF, 8'h22, 0, 0, 8'h0, 8'h0);
        cyc("R2", 1, 0, 24'h7E0010, 8'h00, 0, 0, 8'h0, 8'h0);
        cyc("R2", 1, 0, 24'hBF1FFF, 8'h00, 0, 0, 8'h0, 8'h0);
        cyc("R2", 1, 0, 24'h3F0000, 8'h00, 0, 0, 8'h0, 8'h0);
        cyc("R2", 1, 0, 24'h7F0010, 8'h00, 0, 0, 8'h0, 8'h0);
        idle("R2");
        // R3: unmapped A addresses
        cyc("R3", 1, 1, 24'h002000, 8'hE1, 0, 0, 8'h0, 8'h0);
        cyc("R3", 1, 1, 24'h002180, 8'hE2, 0, 0, 8'h0, 8'h0);
        cyc("R3", 1, 0, 24'h400000, 8'h00, 0, 0, 8'h0, 8'h0);
        cyc("R3", 1, 1, 24'h7DFFFF, 8'hE3, 0, 0, 8'h0, 8'h0);
        cyc("R3", 1, 0, 24'hC00000, 8'h00, 0, 0, 8'h0, 8'h0);
        cyc("R3", 1, 1, 24'hFF0005, 8'hE4, 0, 0, 8'h0, 8'h0);
        idle("R3");
        // R5/R6: load pointer near the top and stream across the wrap
        set_ptr("R5", 'h1FFFE);
        cyc("R6", 0, 0, 24'h0, 8'h0, 1, 1, 8'h80, 8'hC1);
        cyc("R6", 0, 0, 24'h0, 8'h0, 1, 1, 8'h80, 8'hC2);
        cyc("R6", 0, 0, 24'h0, 8'h0, 1, 1, 8'h80, 8'hC3);
        // R7: pointer register reads change nothing
        cyc("R7", 0, 0, 24'h0, 8'h0, 1, 0, 8'h81, 8'h0);
        cyc("R7", 0, 0, 24'h0, 8'h0, 1, 0, 8'h82, 8'h0);
        cyc("R7", 0, 0, 24'h0, 8'h0, 1, 0, 8'h83, 8'h0);
        cyc("R7", 0, 0, 24'h0, 8'h0, 1, 0, 8'h80, 8'h0);
        idle("R7");
        // R4: read back through the gate
        set_ptr("R4", 'h1FFFE);
        cyc("R4", 0, 0, 24'h0, 8'h0, 1, 0, 8'h80, 8'h0);
        cyc("R4", 0, 0, 24'h0, 8'h0, 1, 0, 8'h80, 8'h0);
        cyc("R4", 0, 0, 24'h0, 8'h0, 1, 0, 8'h80, 8'h0);
        cyc("R4", 1, 0, 24'h7E0000, 8'h0, 0, 0, 8'h0, 8'h0);
        idle("R4");
        // R8: contention
        set_ptr("R8", 'h00100);
        cyc("R8", 1, 1, 24'h7E0200, 8'h71, 1, 1, 8'h80, 8'h55);
        cyc("R8", 1, 1, 24'h7E0201, 8'h72, 1, 1, 8'h80, 8'h55);
        cyc("R8", 1, 1, 24'h7E0201, 8'h72, 1, 1, 8'h80, 8'h56);
        cyc("R8", 1, 1, 24'h7E0202, 8'h73, 1, 1, 8'h80, 8'h56);
        cyc("R8", 1, 0, 24'h7E0100, 8'h00, 0, 0, 8'h0, 8'h0);
        cyc("R8", 1, 0, 24'h7E0101, 8'h00, 0, 0, 8'h0, 8'h0);
        cyc("R8", 1, 0, 24'h500000, 8'h00, 1, 0, 8'h80, 8'h0);
        // R5: pointer write alongside an A access
        cyc("R5", 1, 0, 24'h7E0201, 8'h00, 1, 1, 8'h81, 8'h40);
        cyc("R5", 0, 0, 24'h0, 8'h0, 1, 0, 8'h80, 8'h0);
        idle("R5");
        idle("R9");
    endtask

    initial begin
        bit timed_out = 0;
        rst_n = 0;
        a_req = 0; a_we = 0; a_addr = '0; a_wdata = '0;
        b_req = 0; b_we = 0; b_addr = '0; b_wdata = '0;
        m_ptr = 0; m_wait = 0; e_arv = 0; e_brv = 0; e_rd = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule